// File: doc/BRIEF.md
# Partition-Bounded Comparand and Sliding Mask Unit

This unit keeps two 64-bit search registers for a content-addressable lookup engine. The first is a comparand, the search key. The second is a sliding mask, which selects the bits that take part in a compare. A 3-bit partition code splits each 64-bit word into a CAM field and a RAM field on 16-bit boundaries. Single-step shift commands act only inside the CAM field. Bits in the RAM field are never moved by a shift.

A shift of the comparand is a rotation: the bit that leaves one end of the CAM field enters at the other end. A shift of the mask is a slide: the edge bit of the CAM field on the side the shift starts from is copied inward and keeps its own value. Nothing wraps around in a mask shift.

Either register can also take a parallel load through a write mask. A write-mask bit of 0 lets the new data bit in, and a write-mask bit of 1 protects the old bit. Each register has its own action selector with four values: HOLD, LOAD, SHR and SHL. On every clock edge a register moves from its current value to the value that the selected action produces. The selector has no other states and no stored transitions. The match array and the host bus are outside this block.

Top module: `cam_key_shifter`

## Requirements
- R1: While `rst_n` is low, `cmp_out` is all zeros and `msk_out` is all ones.
- R2: The partition code selects the CAM field as follows, with bit 63 the MSB. Codes 0 and 7 select bits 63..0. Code 1 selects bits 63..16, code 2 selects 63..32 and code 3 selects 63..48. Code 4 selects bits 47..0, code 5 selects 31..0 and code 6 selects 15..0.
- R3: `cmp_shr` shifts the comparand's CAM field one place toward the LSB, and the old bit at the field's lowest position appears at its highest position.
- R4: `cmp_shl` shifts the comparand's CAM field one place toward the MSB, and the old bit at the field's highest position appears at its lowest position.
- R5: `msk_shr` shifts the mask's CAM field one place toward the LSB. The highest bit of the field keeps its value, so the field does not wrap.
- R6: `msk_shl` shifts the mask's CAM field one place toward the MSB. The lowest bit of the field keeps its value, so the field does not wrap.
- R7: A shift never changes a bit that lies outside the CAM field.
- R8: `ld_cmp` or `ld_msk` writes `ld_data` into its register on the next edge. Bits where `ld_wmask` is 0 take the new data, and bits where it is 1 keep their old value.
- R9: If a load and a shift of the same register are requested in the same cycle, the load is performed and the shift is dropped.
- R10: If both shift directions are requested for one register in the same cycle, the right shift is performed. With no command, a register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| part_code | input | 3 | CAM/RAM partition code |
| ld_cmp | input | 1 | Masked load into the comparand |
| ld_msk | input | 1 | Masked load into the mask |
| ld_data | input | 64 | Load data |
| ld_wmask | input | 64 | Write mask, 0 = update |
| cmp_shr | input | 1 | Rotate the comparand right within the partition |
| cmp_shl | input | 1 | Rotate the comparand left within the partition |
| msk_shr | input | 1 | Slide the mask right with edge replication |
| msk_shl | input | 1 | Slide the mask left with edge replication |
| cmp_out | output | 64 | Comparand register |
| msk_out | output | 64 | Mask register |

## Verification
Both registers drive the outputs directly, so a wrong bound, a wrong wrap source or a wrong edge copy shows on `cmp_out` or `msk_out` on the clock edge after the command. Each shift is compared bit for bit against a model that is recomputed from the partition code. The model also checks the RAM field, so a wrong bound shows there as well. A bit lost or duplicated in a rotation changes the number of ones at once. A slide that wraps instead of replicating changes the edge bit on the first step.

// File: rtl/cam_shift_pkg.sv
package cam_shift_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_SHR,
        ACT_SHL
    } reg_act_e;
endpackage

// File: rtl/cam_part_bounds.sv
module cam_part_bounds #(
    parameter int W   = 64,
    parameter int SEG = 16,
    parameter int IW  = $clog2(W)
) (
    input  logic [2:0]    code,
    output logic [IW-1:0] lo,
    output logic [IW-1:0] hi,
    output logic [W-1:0]  in_part
);
    int lo_i;
    int hi_i;

    always_comb begin
        lo_i = 0;
        hi_i = W - 1;
        case (code)
            3'd1, 3'd2, 3'd3: lo_i = int'(code) * SEG;
            3'd4, 3'd5, 3'd6: hi_i = W - 1 - (int'(code) - 3) * SEG;
            default: ;
        endcase
        if (lo_i > W - 1) lo_i = 0;
        if (hi_i < 0) hi_i = W - 1;
    end

    assign lo = lo_i[IW-1:0];
    assign hi = hi_i[IW-1:0];

    for (genvar i = 0; i < W; i++) begin : g_inside
        localparam logic [IW-1:0] IDX = IW'(i);
        assign in_part[i] = (IDX >= lo) && (IDX <= hi);
    end
endmodule

// File: rtl/cam_cmp_rotator.sv
module cam_cmp_rotator #(
    parameter int W  = 64,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  cur,
    input  logic [IW-1:0] lo,
    input  logic [IW-1:0] hi,
    input  logic [W-1:0]  in_part,
    input  logic          go_left,
    output logic [W-1:0]  nxt
);
    logic [W-1:0] from_above;
    logic [W-1:0] from_below;

    assign from_above = {cur[0], cur[W-1:1]};
    assign from_below = {cur[W-2:0], cur[W-1]};

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [IW-1:0] IDX = IW'(i);
        always_comb begin
            if (!in_part[i])
                nxt[i] = cur[i];
            else if (!go_left)
                nxt[i] = (IDX == hi) ? cur[lo] : from_above[i];
            else
                nxt[i] = (IDX == lo) ? cur[hi] : from_below[i];
        end
    end
endmodule

// File: rtl/cam_msk_slider.sv
module cam_msk_slider #(
    parameter int W  = 64,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  cur,
    input  logic [IW-1:0] lo,
    input  logic [IW-1:0] hi,
    input  logic [W-1:0]  in_part,
    input  logic          go_left,
    output logic [W-1:0]  nxt
);
    logic [W-1:0] from_above;
    logic [W-1:0] from_below;

    assign from_above = {cur[0], cur[W-1:1]};
    assign from_below = {cur[W-2:0], cur[W-1]};

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [IW-1:0] IDX = IW'(i);
        always_comb begin
            if (!in_part[i])
                nxt[i] = cur[i];
            else if (!go_left)
                nxt[i] = (IDX == hi) ? cur[i] : from_above[i];
            else
                nxt[i] = (IDX == lo) ? cur[i] : from_below[i];
        end
    end
endmodule

// File: rtl/cam_key_shifter.sv
module cam_key_shifter
    import cam_shift_pkg::*;
#(
    parameter int W   = 64,
    parameter int SEG = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   part_code,
    input  logic         ld_cmp,
    input  logic         ld_msk,
    input  logic [W-1:0] ld_data,
    input  logic [W-1:0] ld_wmask,
    input  logic         cmp_shr,
    input  logic         cmp_shl,
    input  logic         msk_shr,
    input  logic         msk_shl,
    output logic [W-1:0] cmp_out,
    output logic [W-1:0] msk_out
);
    localparam int IW = $clog2(W);

    logic [IW-1:0] lo;
    logic [IW-1:0] hi;
    logic [W-1:0]  in_part;
    logic [W-1:0]  cmp_q, msk_q;
    logic [W-1:0]  cmp_rot, msk_sld;
    reg_act_e      cmp_act, msk_act;

    cam_part_bounds #(.W(W), .SEG(SEG), .IW(IW)) u_bounds (
        .code(part_code), .lo(lo), .hi(hi), .in_part(in_part)
    );

    cam_cmp_rotator #(.W(W), .IW(IW)) u_rot (
        .cur(cmp_q), .lo(lo), .hi(hi), .in_part(in_part),
        .go_left(cmp_act == ACT_SHL), .nxt(cmp_rot)
    );

    cam_msk_slider #(.W(W), .IW(IW)) u_sld (
        .cur(msk_q), .lo(lo), .hi(hi), .in_part(in_part),
        .go_left(msk_act == ACT_SHL), .nxt(msk_sld)
    );

    // action select: load beats shift, right beats left
    always_comb begin
        if (ld_cmp)       cmp_act = ACT_LOAD;
        else if (cmp_shr) cmp_act = ACT_SHR;
        else if (cmp_shl) cmp_act = ACT_SHL;
        else              cmp_act = ACT_HOLD;
        if (ld_msk)       msk_act = ACT_LOAD;
        else if (msk_shr) msk_act = ACT_SHR;
        else if (msk_shl) msk_act = ACT_SHL;
        else              msk_act = ACT_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
            msk_q <= '1;
        end else begin
            unique case (cmp_act)
                ACT_LOAD:         cmp_q <= (cmp_q & ld_wmask) | (ld_data & ~ld_wmask);
                ACT_SHR, ACT_SHL: cmp_q <= cmp_rot;
                default:          ;
            endcase
            unique case (msk_act)
                ACT_LOAD:         msk_q <= (msk_q & ld_wmask) | (ld_data & ~ld_wmask);
                ACT_SHR, ACT_SHL: msk_q <= msk_sld;
                default:          ;
            endcase
        end
    end

    always_comb begin
        cmp_out = cmp_q;
        msk_out = msk_q;
    end

    logic [W-1:0] hi_bit, lo_bit;
    assign hi_bit = W'(1) << hi;
    assign lo_bit = W'(1) << lo;

    AST_CMP_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_cmp && (cmp_shr || cmp_shl)) |=> $countones(cmp_out) == $countones($past(cmp_out))); // R3
    AST_CMP_OUTSIDE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_cmp && (cmp_shr || cmp_shl)) |=> ((cmp_out ^ $past(cmp_out)) & ~$past(in_part)) == '0); // R7
    AST_MSK_OUTSIDE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_msk && (msk_shr || msk_shl)) |=> ((msk_out ^ $past(msk_out)) & ~$past(in_part)) == '0); // R7
    AST_MSK_TOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_msk && msk_shr) |=> ((msk_out ^ $past(msk_out)) & $past(hi_bit)) == '0); // R5
    AST_MSK_LOW_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_msk && !msk_shr && msk_shl) |=> ((msk_out ^ $past(msk_out)) & $past(lo_bit)) == '0); // R6
    AST_LOAD_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cmp |=> ((cmp_out ^ $past(cmp_out)) & $past(ld_wmask)) == '0); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_cmp && !ld_msk && !cmp_shr && !cmp_shl && !msk_shr && !msk_shl)
        |=> ($stable(cmp_out) && $stable(msk_out))); // R10
endmodule

// File: tb/cam_key_shifter_test.sv
module cam_key_shifter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  part_code = 0;
    logic        ld_cmp = 0, ld_msk = 0;
    logic [63:0] ld_data = 0, ld_wmask = 0;
    logic        cmp_shr = 0, cmp_shl = 0, msk_shr = 0, msk_shl = 0;
    logic [63:0] cmp_out, msk_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    cam_key_shifter uut (
        .clk(clk), .rst_n(rst_n), .part_code(part_code),
        .ld_cmp(ld_cmp), .ld_msk(ld_msk), .ld_data(ld_data), .ld_wmask(ld_wmask),
        .cmp_shr(cmp_shr), .cmp_shl(cmp_shl), .msk_shr(msk_shr), .msk_shl(msk_shl),
        .cmp_out(cmp_out), .msk_out(msk_out)
    );

    typedef struct {
        logic [63:0] c;
        logic [63:0] m;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          bad = 0;
    bit          done = 0;
    logic [63:0] mc, mm;

    // partition limits from R2
    task automatic limits(input logic [2:0] code, output int lo, output int hi);
        lo = 0; hi = 63;
        case (code)
            3'd1: lo = 16;
            3'd2: lo = 32;
            3'd3: lo = 48;
            3'd4: hi = 47;
            3'd5: hi = 31;
            3'd6: hi = 15;
            default: ;
        endcase
    endtask

    // kind 0 rotate right, 1 rotate left, 2 slide right, 3 slide left
    function automatic logic [63:0] shifted(input logic [63:0] v, input int lo, input int hi, input int kind);
        logic [63:0] r = v;
        for (int i = lo; i <= hi; i++) begin
            case (kind)
                0: r[i] = (i == hi) ? v[lo] : v[i+1];
                1: r[i] = (i == lo) ? v[hi] : v[i-1];
                2: r[i] = (i == hi) ? v[i]  : v[i+1];
                default: r[i] = (i == lo) ? v[i] : v[i-1];
            endcase
        end
        return r;
    endfunction

    task automatic step(input logic [2:0] code, input logic lc, input logic lm,
                        input logic [63:0] d, input logic [63:0] wm,
                        input logic scr, input logic scl, input logic smr, input logic sml,
                        input string tag);
        int lo, hi;
        exp_t e;
        @(negedge clk);
        part_code = code; ld_cmp = lc; ld_msk = lm; ld_data = d; ld_wmask = wm;
        cmp_shr = scr; cmp_shl = scl; msk_shr = smr; msk_shl = sml;
        limits(code, lo, hi);
        if (lc)       mc = (mc & wm) | (d & ~wm);
        else if (scr) mc = shifted(mc, lo, hi, 0);
        else if (scl) mc = shifted(mc, lo, hi, 1);
        if (lm)       mm = (mm & wm) | (d & ~wm);
        else if (smr) mm = shifted(mm, lo, hi, 2);
        else if (sml) mm = shifted(mm, lo, hi, 3);
        e.c = mc; e.m = mm; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compare one expected item per edge, just after the edge
    always @(posedge clk) begin
        #1;
        if (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (cmp_out !== e.c || msk_out !== e.m) begin
                bad++;
                $display("FAIL %s: cmp=%h exp %h msk=%h exp %h", e.tag, cmp_out, e.c, msk_out, e.m);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: cycles exhausted, exp finished run");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic [63:0] w;
        repeat (3) @(negedge clk);
        checks++;
        if (cmp_out !== 64'h0 || msk_out !== '1) begin
            bad++;
            $display("FAIL R1: cmp=%h exp 0 msk=%h exp all ones", cmp_out, msk_out);
        end
        mc = '0; mm = '1;
        @(negedge clk); rst_n = 1;

        // full loads into both registers
        step(0, 1, 0, 64'h8000_0000_0000_0001, 64'h0, 0, 0, 0, 0, "R8 cmp load");
        step(0, 0, 1, 64'h7FFF_0000_0000_FFFE, 64'h0, 0, 0, 0, 0, "R8 msk load");
        step(0, 0, 0, 64'h0, 64'h0, 1, 0, 1, 0, "R2 R3 R5 full width");
        step(0, 0, 0, 64'h0, 64'h0, 0, 1, 0, 1, "R2 R4 R6 full width");

        for (int code = 0; code < 8; code++) begin
            d = {$urandom, $urandom};
            w = {$urandom, $urandom};
            step(3'(code), 1, 1, d, 64'h0, 0, 0, 0, 0, "R8 reload");
            for (int k = 0; k < 3; k++)
                step(3'(code), 0, 0, 64'h0, 64'h0, 1, 0, 0, 0, "R2 R3 R7 cmp right");
            for (int k = 0; k < 4; k++)
                step(3'(code), 0, 0, 64'h0, 64'h0, 0, 1, 0, 0, "R2 R4 R7 cmp left");
            for (int k = 0; k < 3; k++)
                step(3'(code), 0, 0, 64'h0, 64'h0, 0, 0, 1, 0, "R2 R5 R7 msk right");
            step(3'(code), 0, 1, {$urandom, $urandom}, 64'h0, 0, 0, 0, 0, "R8 msk reload");
            for (int k = 0; k < 3; k++)
                step(3'(code), 0, 0, 64'h0, 64'h0, 0, 0, 0, 1, "R2 R6 R7 msk left");
            step(3'(code), 1, 1, {$urandom, $urandom}, w, 0, 0, 0, 0, "R8 partial load");
            step(3'(code), 1, 0, {$urandom, $urandom}, w, 1, 0, 0, 0, "R9 cmp load beats shift");
            step(3'(code), 0, 1, {$urandom, $urandom}, w, 0, 0, 0, 1, "R9 msk load beats shift");
            step(3'(code), 0, 0, 64'h0, 64'h0, 1, 1, 1, 1, "R10 right beats left");
            step(3'(code), 0, 0, {$urandom, $urandom}, 64'h0, 0, 0, 0, 0, "R10 idle hold");
        end

        // slide edge with a single distinct top bit in code 1 field
        step(1, 0, 1, 64'h8000_0000_0000_0000, 64'h0, 0, 0, 0, 0, "R8 msk edge load");
        for (int k = 0; k < 5; k++)
            step(1, 0, 0, 64'h0, 64'h0, 0, 0, 1, 0, "R5 edge replicate");
        step(6, 0, 1, 64'h0000_0000_0000_0001, 64'h0, 0, 0, 0, 0, "R8 msk edge load");
        for (int k = 0; k < 5; k++)
            step(6, 0, 0, 64'h0, 64'h0, 0, 0, 0, 1, "R6 edge replicate");

        @(negedge clk);
        ld_cmp = 0; ld_msk = 0; cmp_shr = 0; cmp_shl = 0; msk_shr = 0; msk_shl = 0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule